// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides how deeply a small processor-based system powers down when the processor asks to sleep. A configuration word written by the processor holds these settings: a deep-sleep select, a power-down select, a low-power-regulator select, a re-sleep-after-handler flag, an interrupt-to-event flag, a backup-write enable and one enable per wakeup pin. When the processor raises a sleep request, the sequencer uses those bits to pick one of three depths. In Sleep only the core clock is gated. In Stop every clock is gated, the oscillators are off and the regulator stays up. In Standby the core domain loses power.

Each depth has its own wake sources. Interrupts or events end Sleep and Stop. Only rising edges on enabled wakeup pins, or the always-on wake sources, end Standby, and that exit goes through a reset pulse rather than a resume. A one-bit event latch supports wait-for-event requests. When Stop used the low-power regulator, the wake from Stop adds a programmable settling delay. The block also drives the write gate for the backup domain.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in Run (modeState 0). coreClkEn, sysClkEn, oscEn and coreDomainOn are 1. regLowPower, bkpWrEn, clkSelInternal, standbyRstReq and wfeReturn are 0.
- R2: Configuration bit positions are: 0 deep-sleep, 1 power-down, 2 low-power regulator, 3 sleep-on-exit, 4 event-on-pend, 5 backup write, 6+i enable for wakeup pin i. A sleep request in Run with deep-sleep clear enters Sleep (modeState 1). In Sleep, coreClkEn is 0 and sysClkEn, oscEn and coreDomainOn are 1.
- R3: A request with deep-sleep set and power-down clear enters Stop (modeState 2). In Stop, coreClkEn, sysClkEn and oscEn are 0, and regLowPower equals the low-power regulator bit as it stood at entry. In the first Run cycle after Stop, clkSelInternal is 1 for exactly one cycle. It stays 0 after a wake from Sleep.
- R4: On a wake from Stop entered with the low-power regulator, the block spends wakeDelay extra cycles in modeState 2 with oscEn 1 and clocks gated, then enters Run. With the normal regulator, or with wakeDelay 0, Run follows on the wake edge.
- R5: A request with both deep-sleep and power-down set enters Standby (modeState 3, coreDomainOn 0). A wake from Standby gives one cycle with standbyRstReq 1, then Run. Every configuration bit except the pin enables is cleared.
- R6: A wakeup pin ends Standby only when its enable bit is set and its level rises between two cycles. A pin that is already high at entry, or that is disabled, does not wake the block.
- R7: Any bit of wakeSrc (the always-on timer, tamper, external-reset and watchdog wake lines) ends Standby.
- R8: bkpWrEn follows the backup-write bit of the configuration word, one cycle after the write.
- R9: A handlerExit pulse in Run with sleep-on-exit set enters Sleep as a wait-for-interrupt sleep. With the bit clear, the pulse has no effect.
- R10: The event latch is set by evtIn or sevPulse. A wait-for-event request with the latch set leaves the block in Run, clears the latch and gives a one-cycle wfeReturn pulse. With the latch clear, the request sleeps, and only an event ends that sleep; irqPending alone does not.
- R11: With event-on-pend set, a rise of irqPending counts as an event and wakes a wait-for-event sleep on that same edge.
- R12: irqPending wakes a wait-for-interrupt Sleep or Stop on the edge where it is seen, and it does not end Standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 6+NPINS | Configuration word |
| wakeDelay | input | DLY_W | Extra cycles after a low-power-regulator Stop |
| sleepReq | input | 1 | Sleep request pulse |
| sleepIsWfe | input | 1 | 1 = wait-for-event request, 0 = wait-for-interrupt |
| handlerExit | input | 1 | Return from the last interrupt handler |
| irqPending | input | 1 | An enabled interrupt is pending |
| evtIn | input | 1 | External event pulse |
| sevPulse | input | 1 | Send-event pulse from the processor |
| wakePins | input | NPINS | Wakeup pins |
| wakeSrc | input | NSRC | Always-on Standby wake lines |
| modeState | output | 2 | 0 Run, 1 Sleep, 2 Stop, 3 Standby |
| coreClkEn | output | 1 | Core clock gate enable |
| sysClkEn | output | 1 | System clock gate enable |
| oscEn | output | 1 | PLL and oscillator enable |
| regLowPower | output | 1 | Regulator in low-power mode |
| coreDomainOn | output | 1 | Core domain power switch |
| clkSelInternal | output | 1 | Force the system clock to the internal RC oscillator |
| standbyRstReq | output | 1 | Reset request on Standby exit |
| wfeReturn | output | 1 | Wait-for-event request returned at once |
| bkpWrEn | output | 1 | Backup-domain write enable |

## Verification
A mode change caused by a request, a handler exit or a wake source shows on modeState one edge after the stimulus is first seen. clkSelInternal and wfeReturn appear in that same first cycle. Standby reaches Run two edges after its wake source, and a low-power-regulator Stop reaches Run one edge plus wakeDelay edges after its wake. The bench drives each stimulus just after a clock edge and samples one time unit after the edge the requirement names. Mode-change latencies are measured by counting edges until modeState returns to Run, and the count is compared with the expected value.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_STOP    = 2'd2,
    MODE_STANDBY = 2'd3
  } pwrMode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_STOP,
    ST_STOP_WAKE,
    ST_STBY,
    ST_STBY_EXIT
  } seqState_e;

  // configuration word bit positions
  localparam int CFG_DEEP  = 0;
  localparam int CFG_PDOWN = 1;
  localparam int CFG_LPREG = 2;
  localparam int CFG_SOE   = 3;
  localparam int CFG_SEVP  = 4;
  localparam int CFG_BKP   = 5;
  localparam int CFG_PIN0  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic clrEvt;
    logic loadCnt;
    logic decCnt;
    logic stbyReset;
    logic markIntOsc;
  } seqStrobe_t;

endpackage

// File: rtl/pwr_seq_dpath.sv
module pwr_seq_dpath
  import pwr_seq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int NSRC  = 6,
  parameter int DLY_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [CFG_PIN0+NPINS-1:0] cfgData,
  input  logic [DLY_W-1:0]          wakeDelay,
  input  logic                      irqPending,
  input  logic                      evtIn,
  input  logic                      sevPulse,
  input  logic [NPINS-1:0]          wakePins,
  input  logic [NSRC-1:0]           wakeSrc,
  input  seqStrobe_t                strb,
  output logic                      cfgDeep,
  output logic                      cfgPdown,
  output logic                      cfgLpReg,
  output logic                      cfgSoe,
  output logic                      bkpWrEn,
  output logic                      evtHit,
  output logic                      stbyWake,
  output logic                      cntZero,
  output logic                      dlyZero,
  output logic                      clkSelInternal
);

  localparam int CFG_W = CFG_PIN0 + NPINS;

  logic [CFG_W-1:0] cfgQ;
  logic [NPINS-1:0] pinPrev;
  logic [NPINS-1:0] pinRise;
  logic             irqPrev;
  logic             evtQ;
  logic             evtSet;
  logic [DLY_W-1:0] cnt;

  // configuration: the standby reset keeps only the pin enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (strb.stbyReset) begin
      cfgQ <= {cfgQ[CFG_W-1:CFG_PIN0], {CFG_PIN0{1'b0}}};
    end else if (cfgWe) begin
      cfgQ <= cfgData;
    end
  end

  assign cfgDeep  = cfgQ[CFG_DEEP];
  assign cfgPdown = cfgQ[CFG_PDOWN];
  assign cfgLpReg = cfgQ[CFG_LPREG];
  assign cfgSoe   = cfgQ[CFG_SOE];
  assign bkpWrEn  = cfgQ[CFG_BKP];

  // wakeup pin rising-edge detection, one slice per pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= wakePins;
  end

  for (genvar i = 0; i < NPINS; i++) begin : gPin
    assign pinRise[i] = wakePins[i] & ~pinPrev[i] & cfgQ[CFG_PIN0+i];
  end

  assign stbyWake = (|pinRise) | (|wakeSrc);

  // event latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPrev <= 1'b0;
    else       irqPrev <= irqPending;
  end

  assign evtSet = evtIn | sevPulse | (cfgQ[CFG_SEVP] & irqPending & ~irqPrev);
  assign evtHit = evtQ | evtSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            evtQ <= 1'b0;
    else if (strb.clrEvt) evtQ <= 1'b0;
    else                  evtQ <= evtHit;
  end

  // regulator settling counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.loadCnt) cnt <= wakeDelay - DLY_W'(1);
    else if (strb.decCnt)  cnt <= cnt - DLY_W'(1);
  end

  assign cntZero = (cnt == '0);
  assign dlyZero = (wakeDelay == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkSelInternal <= 1'b0;
    else       clkSelInternal <= strb.markIntOsc;
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       sleepIsWfe,
  input  logic       handlerExit,
  input  logic       irqPending,
  input  logic       cfgDeep,
  input  logic       cfgPdown,
  input  logic       cfgLpReg,
  input  logic       cfgSoe,
  input  logic       evtHit,
  input  logic       stbyWake,
  input  logic       cntZero,
  input  logic       dlyZero,
  output seqStrobe_t strb,
  output pwrMode_e   mode,
  output logic       coreClkEn,
  output logic       sysClkEn,
  output logic       oscEn,
  output logic       regLowPower,
  output logic       coreDomainOn,
  output logic       standbyRstReq,
  output logic       wfeReturn
);

  seqState_e state, stateNxt;
  logic      kindWfe, kindWfeNxt;
  logic      lpUsed, lpUsedNxt;
  logic      wfeRetNxt;
  logic      wakeHit;

  assign wakeHit = kindWfe ? evtHit : irqPending;

  always_comb begin
    stateNxt   = state;
    kindWfeNxt = kindWfe;
    lpUsedNxt  = lpUsed;
    wfeRetNxt  = 1'b0;
    strb       = '0;
    unique case (state)
      ST_RUN: begin
        if (sleepReq) begin
          if (sleepIsWfe && evtHit) begin
            strb.clrEvt = 1'b1;
            wfeRetNxt   = 1'b1;
          end else begin
            kindWfeNxt = sleepIsWfe;
            lpUsedNxt  = cfgLpReg;
            if (!cfgDeep)      stateNxt = ST_SLEEP;
            else if (!cfgPdown) stateNxt = ST_STOP;
            else               stateNxt = ST_STBY;
          end
        end else if (handlerExit && cfgSoe) begin
          kindWfeNxt = 1'b0;
          stateNxt   = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (wakeHit) begin
          strb.clrEvt = kindWfe;
          stateNxt    = ST_RUN;
        end
      end
      ST_STOP: begin
        if (wakeHit) begin
          strb.clrEvt = kindWfe;
          if (lpUsed && !dlyZero) begin
            strb.loadCnt = 1'b1;
            stateNxt     = ST_STOP_WAKE;
          end else begin
            strb.markIntOsc = 1'b1;
            stateNxt        = ST_RUN;
          end
        end
      end
      ST_STOP_WAKE: begin
        if (cntZero) begin
          strb.markIntOsc = 1'b1;
          stateNxt        = ST_RUN;
        end else begin
          strb.decCnt = 1'b1;
        end
      end
      ST_STBY: begin
        if (stbyWake) stateNxt = ST_STBY_EXIT;
      end
      ST_STBY_EXIT: begin
        strb.stbyReset = 1'b1;
        strb.clrEvt    = 1'b1;
        kindWfeNxt     = 1'b0;
        lpUsedNxt      = 1'b0;
        stateNxt       = ST_RUN;
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      kindWfe   <= 1'b0;
      lpUsed    <= 1'b0;
      wfeReturn <= 1'b0;
    end else begin
      state     <= stateNxt;
      kindWfe   <= kindWfeNxt;
      lpUsed    <= lpUsedNxt;
      wfeReturn <= wfeRetNxt;
    end
  end

  // per-state power outputs
  always_comb begin
    mode          = MODE_RUN;
    coreClkEn     = 1'b1;
    sysClkEn      = 1'b1;
    oscEn         = 1'b1;
    regLowPower   = 1'b0;
    coreDomainOn  = 1'b1;
    standbyRstReq = 1'b0;
    unique case (state)
      ST_RUN: ;
      ST_SLEEP: begin
        mode      = MODE_SLEEP;
        coreClkEn = 1'b0;
      end
      ST_STOP: begin
        mode        = MODE_STOP;
        coreClkEn   = 1'b0;
        sysClkEn    = 1'b0;
        oscEn       = 1'b0;
        regLowPower = lpUsed;
      end
      ST_STOP_WAKE: begin
        mode      = MODE_STOP;
        coreClkEn = 1'b0;
        sysClkEn  = 1'b0;
      end
      ST_STBY: begin
        mode         = MODE_STANDBY;
        coreClkEn    = 1'b0;
        sysClkEn     = 1'b0;
        oscEn        = 1'b0;
        coreDomainOn = 1'b0;
      end
      ST_STBY_EXIT: begin
        mode          = MODE_STANDBY;
        coreClkEn     = 1'b0;
        sysClkEn      = 1'b0;
        oscEn         = 1'b0;
        standbyRstReq = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int NSRC  = 6,
  parameter int DLY_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [CFG_PIN0+NPINS-1:0] cfgData,
  input  logic [DLY_W-1:0]          wakeDelay,
  input  logic                      sleepReq,
  input  logic                      sleepIsWfe,
  input  logic                      handlerExit,
  input  logic                      irqPending,
  input  logic                      evtIn,
  input  logic                      sevPulse,
  input  logic [NPINS-1:0]          wakePins,
  input  logic [NSRC-1:0]           wakeSrc,
  output logic [1:0]                modeState,
  output logic                      coreClkEn,
  output logic                      sysClkEn,
  output logic                      oscEn,
  output logic                      regLowPower,
  output logic                      coreDomainOn,
  output logic                      clkSelInternal,
  output logic                      standbyRstReq,
  output logic                      wfeReturn,
  output logic                      bkpWrEn
);

  seqStrobe_t strb;
  pwrMode_e   mode;
  logic cfgDeep, cfgPdown, cfgLpReg, cfgSoe;
  logic evtHit, stbyWake, cntZero, dlyZero;

  pwr_seq_dpath #(.NPINS(NPINS), .NSRC(NSRC), .DLY_W(DLY_W)) uDpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .wakeDelay(wakeDelay), .irqPending(irqPending), .evtIn(evtIn),
    .sevPulse(sevPulse), .wakePins(wakePins), .wakeSrc(wakeSrc),
    .strb(strb), .cfgDeep(cfgDeep), .cfgPdown(cfgPdown),
    .cfgLpReg(cfgLpReg), .cfgSoe(cfgSoe), .bkpWrEn(bkpWrEn),
    .evtHit(evtHit), .stbyWake(stbyWake), .cntZero(cntZero),
    .dlyZero(dlyZero), .clkSelInternal(clkSelInternal)
  );

  pwr_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepIsWfe(sleepIsWfe),
    .handlerExit(handlerExit), .irqPending(irqPending),
    .cfgDeep(cfgDeep), .cfgPdown(cfgPdown), .cfgLpReg(cfgLpReg),
    .cfgSoe(cfgSoe), .evtHit(evtHit), .stbyWake(stbyWake),
    .cntZero(cntZero), .dlyZero(dlyZero), .strb(strb), .mode(mode),
    .coreClkEn(coreClkEn), .sysClkEn(sysClkEn), .oscEn(oscEn),
    .regLowPower(regLowPower), .coreDomainOn(coreDomainOn),
    .standbyRstReq(standbyRstReq), .wfeReturn(wfeReturn)
  );

  assign modeState = mode;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int CFG_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [CFG_W-1:0] cfgData,
  input logic [1:0]       modeState,
  input logic             coreClkEn,
  input logic             sysClkEn,
  input logic             coreDomainOn,
  input logic             clkSelInternal,
  input logic             standbyRstReq,
  input logic             wfeReturn,
  input logic             bkpWrEn
);

  assert_sleep_gates_core_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 2'd1) |-> (!coreClkEn && sysClkEn));

  assert_stop_gates_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 2'd2) |-> (!coreClkEn && !sysClkEn));

  assert_intosc_after_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    clkSelInternal |-> (modeState == 2'd0 && $past(modeState) == 2'd2));

  assert_stby_exit_to_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    standbyRstReq |=> (modeState == 2'd0 && coreClkEn));

  assert_stby_unpowered_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 2'd3 && !standbyRstReq) |-> !coreDomainOn);

  assert_bkp_rise_by_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bkpWrEn) |-> ($past(cfgWe) && $past(cfgData[5])));

  assert_wfe_return_in_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    wfeReturn |-> (modeState == 2'd0));

  assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({clkSelInternal, standbyRstReq, wfeReturn}));

endmodule

bind pwr_mode_seq pwr_seq_chk #(.CFG_W(pwr_seq_pkg::CFG_PIN0 + NPINS)) uChk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
  .modeState(modeState), .coreClkEn(coreClkEn), .sysClkEn(sysClkEn),
  .coreDomainOn(coreDomainOn), .clkSelInternal(clkSelInternal),
  .standbyRstReq(standbyRstReq), .wfeReturn(wfeReturn), .bkpWrEn(bkpWrEn)
);

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;

  localparam int NPINS = 8;
  localparam int NSRC  = 6;
  localparam int DLY_W = 8;
  localparam int CFG_W = 6 + NPINS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [CFG_W-1:0] cfgData = '0;
  logic [DLY_W-1:0] wakeDelay = 8'd5;
  logic sleepReq = 1'b0, sleepIsWfe = 1'b0, handlerExit = 1'b0;
  logic irqPending = 1'b0, evtIn = 1'b0, sevPulse = 1'b0;
  logic [NPINS-1:0] wakePins = '0;
  logic [NSRC-1:0]  wakeSrc = '0;
  logic [1:0] modeState;
  logic coreClkEn, sysClkEn, oscEn, regLowPower, coreDomainOn;
  logic clkSelInternal, standbyRstReq, wfeReturn, bkpWrEn;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_seq #(.NPINS(NPINS), .NSRC(NSRC), .DLY_W(DLY_W)) u0 (.*);

  typedef struct packed {
    logic [13:0] cfg;
    logic        wfe;
    logic [1:0]  expMode;
    logic [1:0]  wake;   // 0 irq, 1 event, 2 pin0 rise, 3 wake source
    logic [7:0]  lat;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{14'h000, 1'b0, 2'd1, 2'd0, 8'd1},  // R2 R12 sleep, irq
    '{14'h000, 1'b1, 2'd1, 2'd1, 8'd1},  // R10 wfe sleep, event
    '{14'h001, 1'b0, 2'd2, 2'd0, 8'd1},  // R3 stop normal regulator
    '{14'h005, 1'b0, 2'd2, 2'd0, 8'd6},  // R4 stop low-power regulator
    '{14'h005, 1'b1, 2'd2, 2'd1, 8'd6},  // R4 wfe stop low-power
    '{14'h043, 1'b0, 2'd3, 2'd2, 8'd2},  // R6 standby pin0
    '{14'h003, 1'b0, 2'd3, 2'd3, 8'd2},  // R7 standby wake source
    '{14'h010, 1'b1, 2'd1, 2'd0, 8'd1}   // R11 event on pend
  };

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [CFG_W-1:0] v);
    cfgWe = 1'b1;
    cfgData = v;
    step(1);
    cfgWe = 1'b0;
  endtask

  task automatic request(input logic wfe);
    sleepReq = 1'b1;
    sleepIsWfe = wfe;
    step(1);
    sleepReq = 1'b0;
  endtask

  // {core, sys, osc, lowreg, domain}
  function automatic logic [4:0] expOut(input logic [1:0] m, input logic lp);
    case (m)
      2'd0: return 5'b11101;
      2'd1: return 5'b01101;
      2'd2: return {4'b0000, 1'b1} | {3'b000, lp, 1'b0};
      default: return 5'b00000;
    endcase
  endfunction

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    check("R1 mode", modeState, 0);
    check("R1 outputs", {coreClkEn, sysClkEn, oscEn, regLowPower, coreDomainOn}, 5'b11101);
    check("R1 pulses", {bkpWrEn, clkSelInternal, standbyRstReq, wfeReturn}, 0);

    // R8 backup write gate
    writeCfg(14'h020);
    check("R8 set", bkpWrEn, 1);
    writeCfg(14'h000);
    check("R8 clear", bkpWrEn, 0);

    // table of mode entries and wake latencies
    for (int i = 0; i < 8; i++) begin
      int lat;
      writeCfg(VEC[i].cfg);
      request(VEC[i].wfe);
      check($sformatf("R2/R3/R5 vec%0d mode", i), modeState, VEC[i].expMode);
      check($sformatf("R2/R3/R5 vec%0d outputs", i),
            {coreClkEn, sysClkEn, oscEn, regLowPower, coreDomainOn},
            expOut(VEC[i].expMode, VEC[i].cfg[2]));
      case (VEC[i].wake)
        2'd0: irqPending = 1'b1;
        2'd1: evtIn = 1'b1;
        2'd2: wakePins[0] = 1'b1;
        default: wakeSrc[2] = 1'b1;
      endcase
      step(1);
      evtIn = 1'b0;
      wakeSrc = '0;
      lat = 1;
      while (modeState != 2'd0 && lat < 40) begin
        step(1);
        lat++;
      end
      check($sformatf("R4/R6/R7/R11/R12 vec%0d latency", i), lat, VEC[i].lat);
      irqPending = 1'b0;
      wakePins = '0;
      step(1);
    end

    // R3 internal oscillator select after stop, not after sleep
    writeCfg(14'h001);
    request(1'b0);
    irqPending = 1'b1;
    step(1);
    check("R3 run after stop", modeState, 0);
    check("R3 intosc pulse", clkSelInternal, 1);
    irqPending = 1'b0;
    step(1);
    check("R3 intosc one cycle", clkSelInternal, 0);
    writeCfg(14'h000);
    request(1'b0);
    irqPending = 1'b1;
    step(1);
    check("R3 no intosc after sleep", clkSelInternal, 0);
    irqPending = 1'b0;
    step(1);

    // R4 settling window detail and zero delay
    writeCfg(14'h005);
    request(1'b0);
    irqPending = 1'b1;
    step(1);
    irqPending = 1'b0;
    check("R4 settle mode", modeState, 2);
    check("R4 settle osc on clocks off", {oscEn, sysClkEn, coreClkEn}, 3'b100);
    step(4);
    check("R4 still settling", modeState, 2);
    step(1);
    check("R4 run after delay", modeState, 0);
    check("R4 intosc after delay", clkSelInternal, 1);
    wakeDelay = 8'd0;
    request(1'b0);
    irqPending = 1'b1;
    step(1);
    irqPending = 1'b0;
    check("R4 zero delay", modeState, 0);
    wakeDelay = 8'd5;
    step(1);

    // R10 immediate return and event-only wake
    writeCfg(14'h000);
    sevPulse = 1'b1;
    step(1);
    sevPulse = 1'b0;
    request(1'b1);
    check("R10 stays run", modeState, 0);
    check("R10 return pulse", wfeReturn, 1);
    request(1'b1);
    check("R10 latch consumed, sleeps", modeState, 1);
    irqPending = 1'b1;
    step(3);
    check("R10 R11 irq ignored in wfe", modeState, 1);
    irqPending = 1'b0;
    step(1);
    evtIn = 1'b1;
    step(1);
    evtIn = 1'b0;
    check("R10 event wakes", modeState, 0);

    // R9 sleep-on-exit
    writeCfg(14'h008);
    handlerExit = 1'b1;
    step(1);
    handlerExit = 1'b0;
    check("R9 re-enter sleep", modeState, 1);
    irqPending = 1'b1;
    step(1);
    check("R9 wfi wake", modeState, 0);
    irqPending = 1'b0;
    writeCfg(14'h000);
    handlerExit = 1'b1;
    step(1);
    handlerExit = 1'b0;
    check("R9 ignored when clear", modeState, 0);

    // R6 R12 R5 standby corner cases
    writeCfg(14'h0A3);
    check("R8 set before standby", bkpWrEn, 1);
    wakePins[1] = 1'b1;
    step(1);
    request(1'b0);
    check("R5 standby mode", modeState, 3);
    check("R5 domain off", coreDomainOn, 0);
    step(2);
    check("R6 high level no wake", modeState, 3);
    irqPending = 1'b1;
    step(3);
    check("R12 irq ignored in standby", modeState, 3);
    irqPending = 1'b0;
    wakePins[0] = 1'b1;
    step(2);
    check("R6 disabled pin no wake", modeState, 3);
    wakePins[1] = 1'b0;
    step(1);
    wakePins[1] = 1'b1;
    step(1);
    check("R5 reset request", standbyRstReq, 1);
    step(1);
    check("R5 run after exit", modeState, 0);
    check("R5 reset request one cycle", standbyRstReq, 0);
    check("R5 backup gate cleared", bkpWrEn, 0);
    wakePins = '0;
    request(1'b0);
    check("R5 deep bit cleared", modeState, 1);
    irqPending = 1'b1;
    step(1);
    irqPending = 1'b0;
    step(1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule